// File: doc/BRIEF.md
# GPIO Port Output and Input Data Registers

This block is the data side of a 32-pin general-purpose I/O port. It sits on a simple memory-mapped register bus with an address, a write strobe with write data, and a read strobe with registered read data. The block keeps an output latch that drives the pads directly. Software can overwrite the latch as a whole. It can also set, clear or invert selected pins through three write-one aliases, so no read-modify-write sequence is needed and no other pin is disturbed.

Pad levels come into the block through a two-flop synchronizer and are read from a read-only input register. Pin direction, pin multiplexing, pad electrical control and interrupt generation are handled by other blocks. Bit n of every register belongs to pin n.

Byte offsets are: 0x00 output data (read/write), 0x04 set alias, 0x08 clear alias, 0x0C toggle alias, 0x10 input register (read-only). An access is decoded only when the address exactly matches one of these values.

Top module: `gpio_data_port`

## Requirements
- R1: While rst_ni is low, pad_out_o and rdata_o are all zeros.
- R2: A write to offset 0x00 loads wdata_i into the output latch, and a read of 0x00 returns the latch.
- R3: A write to offset 0x04 sets each latch bit whose wdata_i bit is 1 and leaves every other bit unchanged.
- R4: A write to offset 0x08 clears each latch bit whose wdata_i bit is 1 and leaves every other bit unchanged.
- R5: A write to offset 0x0C inverts each latch bit whose wdata_i bit is 1 and leaves every other bit unchanged.
- R6: A read of offset 0x10 at clock edge n returns the pad_in_i level that was sampled at edge n-2, because of the two synchronizer flops.
- R7: Reads of offsets 0x04, 0x08 and 0x0C return zero.
- R8: A write to offset 0x10 leaves the output latch unchanged.
- R9: An access at any address other than 0x00, 0x04, 0x08, 0x0C and 0x10 reads zero and has no effect when written. This includes misaligned addresses.
- R10: rdata_o is registered. It shows the selected register as it was at the edge where rd_en_i was sampled, and it is zero in any cycle that follows an edge without a read. When a read and a write happen in the same cycle, the read returns the value from before the write.
- R11: pad_out_o always equals the output latch. It changes at the edge that samples a write and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W (8) | Byte address of the access |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | NUM_PINS (32) | Write data / pin mask |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | NUM_PINS (32) | Registered read data |
| pad_in_i | input | NUM_PINS (32) | Asynchronous pad input levels |
| pad_out_o | output | NUM_PINS (32) | Output latch driven to pads |

## Verification
A corrupted output latch shows on pad_out_o on the first edge after the faulty update, because the latch drives the pads directly. The reference model therefore compares pad_out_o every cycle, and a wrong set, clear or toggle mask is caught one cycle after the write. Faults in the synchronizer or the read multiplexer only show up through reads. The bench therefore reads the input register back to back while the pad pattern changes, which exposes a wrong stage count as a one-cycle shift in the returned data. Reads of the aliases, of the input register after writes, and of unmapped or misaligned addresses show whether a decode error leaks into rdata_o or disturbs the latch.

// File: rtl/gpio_data_pkg.sv
package gpio_data_pkg;
  localparam logic [7:0] OFS_DATA = 8'h00;
  localparam logic [7:0] OFS_SET  = 8'h04;
  localparam logic [7:0] OFS_CLR  = 8'h08;
  localparam logic [7:0] OFS_TGL  = 8'h0C;
  localparam logic [7:0] OFS_IN   = 8'h10;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_DATA,
    SEL_SET,
    SEL_CLR,
    SEL_TGL,
    SEL_IN
  } reg_sel_e;
endpackage

// File: rtl/gpio_reg_decode.sv
module gpio_reg_decode
  import gpio_data_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o
);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);
  localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(OFS_SET);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFS_CLR);
  localparam logic [ADDR_W-1:0] A_TGL  = ADDR_W'(OFS_TGL);
  localparam logic [ADDR_W-1:0] A_IN   = ADDR_W'(OFS_IN);

  always_comb begin
    sel_o = SEL_NONE;
    if      (addr_i == A_DATA) sel_o = SEL_DATA;
    else if (addr_i == A_SET)  sel_o = SEL_SET;
    else if (addr_i == A_CLR)  sel_o = SEL_CLR;
    else if (addr_i == A_TGL)  sel_o = SEL_TGL;
    else if (addr_i == A_IN)   sel_o = SEL_IN;
  end
endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch
  import gpio_data_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  reg_sel_e            sel_i,
  input  logic [NUM_PINS-1:0] wdata_i,
  output logic [NUM_PINS-1:0] q_o
);
  logic [NUM_PINS-1:0] q_d;

  always_comb begin
    q_d = q_o;
    if (wr_en_i) begin
      case (sel_i)
        SEL_DATA: q_d = wdata_i;
        SEL_SET:  q_d = q_o | wdata_i;
        SEL_CLR:  q_d = q_o & ~wdata_i;
        SEL_TGL:  q_d = q_o ^ wdata_i;
        default:  q_d = q_o;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= q_d;
  end

  AST_DATA_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && sel_i == SEL_DATA) |=> q_o == $past(wdata_i)); // R2
  AST_SET_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && sel_i == SEL_SET) |=>
      ((q_o & $past(wdata_i)) == $past(wdata_i)) &&
      ((q_o & ~$past(wdata_i)) == ($past(q_o) & ~$past(wdata_i)))); // R3
  AST_CLR_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && sel_i == SEL_CLR) |=>
      ((q_o & $past(wdata_i)) == '0) &&
      ((q_o & ~$past(wdata_i)) == ($past(q_o) & ~$past(wdata_i)))); // R4
  AST_TGL_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && sel_i == SEL_TGL) |=> (q_o ^ $past(q_o)) == $past(wdata_i)); // R5
  AST_HOLD_OTHER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i || sel_i == SEL_IN || sel_i == SEL_NONE) |=> $stable(q_o)); // R8 R9 R11
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned STAGES   = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pad_i,
  output logic [NUM_PINS-1:0] sync_o
);
  logic [NUM_PINS-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= pad_i;
      else             stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_data_port.sv
module gpio_data_port
  import gpio_data_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 32,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                wr_en_i,
  input  logic [NUM_PINS-1:0] wdata_i,
  input  logic                rd_en_i,
  output logic [NUM_PINS-1:0] rdata_o,
  input  logic [NUM_PINS-1:0] pad_in_i,
  output logic [NUM_PINS-1:0] pad_out_o
);
  reg_sel_e            sel;
  logic [NUM_PINS-1:0] latch_q;
  logic [NUM_PINS-1:0] in_sync;
  logic [NUM_PINS-1:0] rd_mux;

  gpio_reg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i (addr_i),
    .sel_o  (sel)
  );

  gpio_out_latch #(.NUM_PINS(NUM_PINS)) u_latch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .sel_i   (sel),
    .wdata_i (wdata_i),
    .q_o     (latch_q)
  );

  gpio_in_sync #(.NUM_PINS(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pad_i  (pad_in_i),
    .sync_o (in_sync)
  );

  // aliases and unmapped offsets read as zero
  always_comb begin
    case (sel)
      SEL_DATA: rd_mux = latch_q;
      SEL_IN:   rd_mux = in_sync;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_mux;
    else              rdata_o <= '0;
  end

  assign pad_out_o = latch_q;

  // cycles since reset, for the input-path check only
  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             age_q <= '0;
    else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
  end

  AST_RD_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> rdata_o == '0); // R10
  AST_ALIAS_RD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && (sel == SEL_SET || sel == SEL_CLR || sel == SEL_TGL || sel == SEL_NONE))
      |=> rdata_o == '0); // R7 R9
  AST_DATA_READBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && sel == SEL_DATA) |=> rdata_o == $past(pad_out_o)); // R2

  if (SYNC_STAGES == 2) begin : g_in_chk
    AST_IN_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (age_q == 2'd3 && rd_en_i && sel == SEL_IN) |=> rdata_o == $past(pad_in_i, 3)); // R6
  end
endmodule

// File: tb/tb_gpio_data_port.sv
module tb_gpio_data_port;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic [7:0]  addr;
  logic        wr_en, rd_en;
  logic [31:0] wdata, pad_in;
  logic [31:0] rdata, pad_out;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  logic [31:0] m_out, m_s1, m_s2, exp_rd, exp_pins;
  string rd_tag, pin_tag;

  always #4 clk = ~clk;

  gpio_data_port dut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wr_en_i(wr_en),
    .wdata_i(wdata), .rd_en_i(rd_en), .rdata_o(rdata),
    .pad_in_i(pad_in), .pad_out_o(pad_out)
  );

  function automatic logic [31:0] rd_model(input logic [7:0] a);
    case (a)
      8'h00:   return m_out;
      8'h10:   return m_s2;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string rd_tag_of(input logic r, input logic [7:0] a);
    if (!r) return "R10";
    case (a)
      8'h00: return "R2";
      8'h10: return "R6";
      8'h04, 8'h08, 8'h0C: return "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare outputs, drive next inputs, advance the model by one edge
  task automatic step(input logic w, input logic r, input logic [7:0] a,
                      input logic [31:0] d, input logic [31:0] p);
    @(negedge clk);
    check(pin_tag, pad_out, exp_pins);
    check(rd_tag, rdata, exp_rd);
    wr_en = w; rd_en = r; addr = a; wdata = d; pad_in = p;
    exp_rd = r ? rd_model(a) : 32'h0;
    rd_tag = (r && w) ? {rd_tag_of(r, a), " R10"} : rd_tag_of(r, a);
    pin_tag = "R11";
    if (w) begin
      case (a)
        8'h00: begin m_out = d;           pin_tag = "R2 R11"; end
        8'h04: begin m_out = m_out | d;   pin_tag = "R3"; end
        8'h08: begin m_out = m_out & ~d;  pin_tag = "R4"; end
        8'h0C: begin m_out = m_out ^ d;   pin_tag = "R5"; end
        8'h10: pin_tag = "R8";
        default: pin_tag = "R9";
      endcase
    end
    m_s2 = m_s1;
    m_s1 = p;
    exp_pins = m_out;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] alist [8] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h02, 8'hFC};
    rst_ni = 1'b0; addr = '0; wr_en = 0; rd_en = 0; wdata = '0; pad_in = 32'hFFFF_FFFF;
    repeat (3) begin
      @(negedge clk);
      check("R1", pad_out, 32'h0);
      check("R1", rdata, 32'h0);
    end
    rst_ni = 1'b1;
    m_out = '0; m_s1 = '0; m_s2 = '0; exp_rd = '0; exp_pins = '0;
    rd_tag = "R1"; pin_tag = "R1";
    pad_in = 32'h0;

    step(1, 0, 8'h00, 32'hA5A5_F00F, 32'h0);
    step(0, 1, 8'h00, 32'h0, 32'h0);
    step(1, 0, 8'h04, 32'h0000_0FF0, 32'h0);
    step(0, 1, 8'h00, 32'h0, 32'h0);
    step(1, 0, 8'h08, 32'hF000_000F, 32'h0);
    step(1, 0, 8'h0C, 32'hFFFF_0000, 32'h0);
    step(0, 1, 8'h04, 32'h0, 32'h0);
    step(0, 1, 8'h08, 32'h0, 32'h0);
    step(0, 1, 8'h0C, 32'h0, 32'h0);
    step(1, 0, 8'h10, 32'hFFFF_FFFF, 32'h0);
    step(1, 0, 8'h14, 32'hFFFF_FFFF, 32'h0);
    step(1, 0, 8'h02, 32'h0000_0000, 32'h0);
    step(1, 0, 8'hFC, 32'h1234_5678, 32'h0);
    step(0, 1, 8'h14, 32'h0, 32'h0);
    step(0, 1, 8'h01, 32'h0, 32'h0);
    step(0, 1, 8'h00, 32'h0, 32'h0);
    // pad pattern walk, input register read every cycle
    for (int i = 0; i < 8; i++)
      step(0, 1, 8'h10, 32'h0, 32'h1 << (i * 4));
    step(0, 1, 8'h10, 32'h0, 32'hDEAD_BEEF);
    step(0, 1, 8'h10, 32'h0, 32'hDEAD_BEEF);
    step(0, 1, 8'h10, 32'h0, 32'hDEAD_BEEF);
    // read and write in the same cycle
    step(1, 1, 8'h00, 32'h0F0F_0F0F, 32'h0);
    step(1, 1, 8'h0C, 32'hFFFF_FFFF, 32'h0);
    step(0, 1, 8'h00, 32'h0, 32'h0);
    // mixed traffic
    for (int i = 0; i < 400; i++)
      step(1'($urandom), 1'($urandom), alist[$urandom % 8], $urandom, $urandom);
    step(0, 0, 8'h00, 32'h0, 32'h0);
    step(0, 0, 8'h00, 32'h0, 32'h0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule